// File: doc/BRIEF.md
# Dual-Channel Register-Mapped PWM Generator

This block is a memory-mapped pulse-width modulator with two independent channels. Each channel owns four word registers (control, prescaler, period, duty) in a 16-byte window, and one shared read-only status word reports which writes are still waiting to reach the active logic. Software writes a register, then polls the status word until the matching bit reads zero. At that point the new value is in use.

Every write goes into a holding register first. It then passes through a fixed synchronisation delay. Control values take effect as soon as they arrive. Prescaler, period and duty values take effect at a boundary. With autoload set, that boundary is the wrap of the period counter, so each waveform period is built from one consistent set of values. With autoload clear, it is the next prescaler tick. On an idle channel, or when a force-load control bit is set, new values take effect on arrival.

The output period is (prescaler+1) × (period+1) clock cycles. The output is active while the period counter is below the duty value, and the polarity bit can invert it. Turning a channel off either stops it at once or lets the current period finish, as the control register selects.

The register port is a plain single-cycle strobe with no back-pressure. A write is taken on any clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`, so it is valid in the same cycle.

Top module: `pwm_dual_ctl`

## Requirements
- R1: Channel c has its registers at byte address c×0x10: control at +0x00 (6 bits), prescaler at +0x04 (10 bits), period at +0x08 (12 bits), duty at +0x0C (12 bits). A read returns the last written value truncated to the field width, and address bits [1:0] are ignored.
- R2: The status word at 0x40 is read-only. Bits c×8+0, +1, +2 and +3 are the pending flags for control, prescaler, period and duty of channel c. All other bits read 0, and writes to 0x40 have no effect.
- R3: A register write sets its pending bit in the next cycle. When the transfer is not deferred, the bit clears exactly 2 clock edges after the write edge. This applies to control always, and to the other registers on an idle channel.
- R4: Slots 2 and 3 (0x20–0x3F) and the addresses above 0x40 read as 0, ignore writes, and leave every channel register and the status word unchanged.
- R5: With control bit 0 (enable) set, the output period is (p+1)(q+1) cycles and the active time is (p+1)×d cycles, where p is the prescaler, q the period and d the duty, for 1 ≤ d ≤ q.
- R6: A duty of 0 gives a constant inactive output. A duty greater than the period value gives a constant active output.
- R7: Control bit 1 inverts the output. The inactive level is then 1, and the output is also 1 while the channel is idle.
- R8: With control bit 2 (autoload) set on a running channel, new prescaler, period and duty values stay pending until the period counter wraps, and take effect from the next period.
- R9: With autoload clear on a running channel, a new value takes effect at the next prescaler tick, at most p+2 cycles after the write.
- R10: Control bit 4 makes a prescaler write, and bit 5 makes a period or duty write, take effect on arrival (pending clears 2 edges after the write) even with autoload set.
- R11: Clearing enable while control bit 3 (stop-immediately) is set forces the output inactive on the third clock edge after the write.
- R12: Clearing enable while bit 3 is clear lets the current period run to its wrap. The output then stays inactive.
- R13: After reset, every register and the status word read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on each rising edge |
| bus_addr | input | 7 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 2 | Waveform output, one bit per channel |

## Verification
The hardest case to reach is a deferred transfer. The status bit must be observed while it is still set, after the synchronisation delay has passed but before the period boundary. The write must also be known not to land on the boundary itself. The bench first lines up with the waveform by waiting for a rising output edge, which marks the start of a period. It then writes a new duty value into a long autoloaded period and checks that the pending bit is still set several cycles later, with the wrap far away. The stop tests use the same alignment, so that the stop-immediately and finish-the-period paths are told apart by sampling the output at known distances from the wrap.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int NREG   = 4;
  localparam int CTRL_W = 6;
  // register index inside a channel window (address bits [3:2])
  localparam int R_CTRL = 0;
  localparam int R_PRE  = 1;
  localparam int R_PER  = 2;
  localparam int R_DUTY = 3;
  // control bit positions
  localparam int C_EN      = 0;
  localparam int C_INV     = 1;
  localparam int C_AUTO    = 2;
  localparam int C_STOPIMM = 3;
  localparam int C_LDPRE   = 4;
  localparam int C_LDPER   = 5;
  localparam int WIN_BYTES = 16;
  localparam int STAT_STRIDE = 8;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W        = 8,
  parameter int SYNC_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         take_i,
  output logic [W-1:0] hold_o,
  output logic         pend_o,
  output logic         ready_o
);
  localparam int AGE_W = $clog2(SYNC_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_RDY = AGE_W'(SYNC_CYC - 1);

  logic [W-1:0]     hold_q;
  logic             pend_q;
  logic [AGE_W-1:0] age_q;

  assign ready_o = pend_q && (age_q >= AGE_RDY);
  assign hold_o  = hold_q;
  assign pend_o  = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      age_q  <= '0;
    end else if (wr_i) begin
      hold_q <= wdata_i;
      pend_q <= 1'b1;
      age_q  <= '0;
    end else begin
      if (pend_q && (age_q < AGE_RDY)) age_q <= age_q + 1'b1;
      if (take_i && ready_o) pend_q <= 1'b0;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_o); // R3
  AST_SYNC_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !ready_o); // R3
  AST_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(take_i)); // R8
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_dual_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_h,
  input  logic [PRE_W-1:0]  pre_h,
  input  logic [PER_W-1:0]  per_h,
  input  logic [PER_W-1:0]  duty_h,
  input  logic [NREG-1:0]   rdy_i,
  output logic [NREG-1:0]   take_o,
  output logic              pwm_o
);
  logic [CTRL_W-1:0] ctrl_a;
  logic [PRE_W-1:0]  pre_a, pre_cnt;
  logic [PER_W-1:0]  per_a, duty_a, per_cnt;
  logic              run_q, run_n;
  logic              tick, wrap, bound, active;

  assign tick  = run_q && (pre_cnt >= pre_a);
  assign wrap  = tick && (per_cnt >= per_a);
  assign bound = ctrl_a[C_AUTO] ? wrap : tick;

  always_comb begin
    take_o         = '0;
    take_o[R_CTRL] = rdy_i[R_CTRL];
    take_o[R_PRE]  = rdy_i[R_PRE]  && (!run_q || ctrl_a[C_LDPRE] || bound);
    take_o[R_PER]  = rdy_i[R_PER]  && (!run_q || ctrl_a[C_LDPER] || bound);
    take_o[R_DUTY] = rdy_i[R_DUTY] && (!run_q || ctrl_a[C_LDPER] || bound);
  end

  always_comb begin
    if (ctrl_a[C_EN])            run_n = 1'b1;
    else if (!run_q)             run_n = 1'b0;
    else if (ctrl_a[C_STOPIMM])  run_n = 1'b0;
    else                         run_n = !wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a  <= '0;
      pre_a   <= '0;
      per_a   <= '0;
      duty_a  <= '0;
      run_q   <= 1'b0;
      pre_cnt <= '0;
      per_cnt <= '0;
    end else begin
      if (take_o[R_CTRL]) ctrl_a <= ctrl_h;
      if (take_o[R_PRE])  pre_a  <= pre_h;
      if (take_o[R_PER])  per_a  <= per_h;
      if (take_o[R_DUTY]) duty_a <= duty_h;
      run_q <= run_n;
      if (!run_n) begin
        pre_cnt <= '0;
        per_cnt <= '0;
      end else if (run_q) begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) per_cnt <= wrap ? '0 : per_cnt + 1'b1;
      end
    end
  end

  assign active = run_q && (per_cnt < duty_a);
  assign pwm_o  = active ^ ctrl_a[C_INV];

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_o == ctrl_a[C_INV])); // R7
  AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ctrl_a[C_EN] && ctrl_a[C_STOPIMM]) |=> !run_q); // R11
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && duty_a == '0) |-> (pwm_o == ctrl_a[C_INV])); // R6
  AST_AUTO_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ctrl_a[C_AUTO] && !ctrl_a[C_LDPER] && !wrap) |-> !take_o[R_DUTY]); // R8
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_dual_pkg::*;
#(
  parameter int PRE_W    = 10,
  parameter int PER_W    = 12,
  parameter int SYNC_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [1:0]      reg_sel_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic [NREG-1:0] pend_o,
  output logic            pwm_o
);
  localparam int MAXW = (PER_W > PRE_W) ? ((PER_W > CTRL_W) ? PER_W : CTRL_W)
                                        : ((PRE_W > CTRL_W) ? PRE_W : CTRL_W);

  function automatic int reg_w(input int r);
    if (r == R_CTRL) return CTRL_W;
    if (r == R_PRE)  return PRE_W;
    return PER_W;
  endfunction

  logic [MAXW-1:0] hold_all [NREG];
  logic [NREG-1:0] rdy, take;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int W = reg_w(r);
    logic [W-1:0] h;
    pwm_shadow_reg #(.W(W), .SYNC_CYC(SYNC_CYC)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_i && (reg_sel_i == 2'(r))),
      .wdata_i (wdata_i[W-1:0]),
      .take_i  (take[r]),
      .hold_o  (h),
      .pend_o  (pend_o[r]),
      .ready_o (rdy[r])
    );
    assign hold_all[r] = MAXW'(h);
  end

  assign rdata_o = 32'(hold_all[reg_sel_i]);

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:MAXW], hold_all[R_CTRL][MAXW-1:CTRL_W],
                         hold_all[R_PRE][MAXW-1:PRE_W]};

  pwm_chan_core #(.PRE_W(PRE_W), .PER_W(PER_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_h (hold_all[R_CTRL][CTRL_W-1:0]),
    .pre_h  (hold_all[R_PRE][PRE_W-1:0]),
    .per_h  (hold_all[R_PER][PER_W-1:0]),
    .duty_h (hold_all[R_DUTY][PER_W-1:0]),
    .rdy_i  (rdy),
    .take_o (take),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/pwm_dual_ctl.sv
module pwm_dual_ctl
  import pwm_dual_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SLOTS    = 4,
  parameter int PRE_W    = 10,
  parameter int PER_W    = 12,
  parameter int SYNC_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int ADDR_W = $clog2(SLOTS * WIN_BYTES) + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(SLOTS * WIN_BYTES);

  function automatic logic [31:0] pend_mask();
    logic [31:0] m = '0;
    for (int c = 0; c < NUM_CH; c++) m[c*STAT_STRIDE +: NREG] = '1;
    return m;
  endfunction
  localparam logic [31:0] PEND_MASK = pend_mask();

  logic              is_chan;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        reg_sel;
  logic [31:0]       ch_rdata [NUM_CH];
  logic [NREG-1:0]   ch_pend  [NUM_CH];
  logic [31:0]       status_w;

  assign is_chan = bus_addr < STATUS_OFS;
  assign slot    = bus_addr[4 +: SLOT_W];
  assign reg_sel = bus_addr[3:2];

  logic unused_lsb;
  assign unused_lsb = ^bus_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan #(.PRE_W(PRE_W), .PER_W(PER_W), .SYNC_CYC(SYNC_CYC)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr && is_chan && (slot == SLOT_W'(c))),
      .reg_sel_i (reg_sel),
      .wdata_i   (bus_wdata),
      .rdata_o   (ch_rdata[c]),
      .pend_o    (ch_pend[c]),
      .pwm_o     (pwm_out[c])
    );
  end

  always_comb begin
    status_w = '0;
    for (int c = 0; c < NUM_CH; c++) status_w[c*STAT_STRIDE +: NREG] = ch_pend[c];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STATUS_OFS) begin
      bus_rdata = status_w;
    end else if (is_chan) begin
      for (int c = 0; c < NUM_CH; c++)
        if (slot == SLOT_W'(c)) bus_rdata = ch_rdata[c];
    end
  end

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_chan && int'(slot) >= NUM_CH) |-> (bus_rdata == '0)); // R4
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STATUS_OFS) |-> ((bus_rdata & ~PEND_MASK) == '0)); // R2
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > STATUS_OFS) |-> (bus_rdata == '0)); // R4
endmodule

// File: tb/test_pwm_dual_ctl.sv
module test_pwm_dual_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  localparam logic [31:0] EN = 32'h01, INV = 32'h02, AUTO = 32'h04,
                          STOP = 32'h08, LDPRE = 32'h10, LDPER = 32'h20;
  localparam logic [6:0] STAT = 7'h40;

  pwm_dual_ctl i_pwm_dual_ctl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int exp_period(input int p, input int q);
    return (p + 1) * (q + 1);
  endfunction
  function automatic int exp_high(input int p, input int d);
    return (p + 1) * d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input int limit, output int n);
    logic [31:0] s;
    n = 0;
    for (int i = 0; i < limit; i++) begin
      rd(STAT, s);
      if (s == 0) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_rise(input int ch, input bit inv);
    bit prev, cur;
    prev = pwm_out[ch] ^ inv;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cur = pwm_out[ch] ^ inv;
      if (!prev && cur) break;
      prev = cur;
    end
  endtask

  task automatic measure(input int ch, input bit inv, output int per, output int hi);
    bit prev, cur;
    wait_rise(ch, inv);
    cur = 1'b1; per = 0; hi = 0;
    for (int i = 0; i < 5000; i++) begin
      hi += int'(cur); per++;
      @(negedge clk);
      prev = cur;
      cur = pwm_out[ch] ^ inv;
      if (!prev && cur) break;
    end
  endtask

  task automatic count_active(input int ch, input bit inv, input int n, output int act);
    act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch] ^ inv) act++;
    end
  endtask

  task automatic cfg(input int ch, input int p, input int q, input int d, input logic [31:0] bits);
    int n;
    logic [6:0] b;
    b = 7'(ch * 16);
    wr(b, STOP);
    wait_idle(50, n);
    wr(b + 7'h4, 32'(p));
    wr(b + 7'h8, 32'(q));
    wr(b + 7'hC, 32'(d));
    wait_idle(50, n);
    wr(b, bits | EN);
    wait_idle(50, n);
  endtask

  initial begin
    logic [31:0] v;
    int n, per, hi, act;
    int unsigned seed;
    seed = $urandom(32'd2024);

    repeat (3) @(negedge clk);
    // R13: reset state
    for (int a = 0; a < 32; a += 4) begin
      rd(7'(a), v); chk("R13 reg reset", v, 0);
    end
    rd(STAT, v); chk("R13 status reset", v, 0);
    chk("R13 outputs reset", 32'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: status byte placement and clear timing for a duty write on idle channel 1
    wr(7'h1C, 32'hFFFF_FFFF);
    rd(STAT, v); chk("R2 ch1 duty pending bit 11", v, 32'h800);
    @(negedge clk); rd(STAT, v); chk("R3 pending after 1 edge", v, 32'h800);
    @(negedge clk); rd(STAT, v); chk("R3 pending cleared after 2 edges", v, 0);
    rd(7'h1C, v); chk("R1 duty width 12", v, 32'hFFF);
    wr(7'h14, 32'hFFFF_FFFF); rd(7'h14, v); chk("R1 prescaler width 10", v, 32'h3FF);
    wr(7'h18, 32'hFFFF_FFFF); rd(7'h18, v); chk("R1 period width 12", v, 32'hFFF);
    wait_idle(50, n);
    wr(7'h10, 32'hFFFF_FFFF);
    rd(STAT, v); chk("R2 ch1 control pending bit 8", v, 32'h100);
    @(negedge clk); @(negedge clk); rd(STAT, v); chk("R3 control pending cleared", v, 0);
    rd(7'h10, v); chk("R1 control width 6", v, 32'h3F);
    wr(7'h10, STOP);
    wr(7'h05, 32'h123); rd(7'h04, v); chk("R1 low address bits ignored", v, 32'h123);
    wait_idle(50, n);
    wr(STAT, 32'hFFFF_FFFF); rd(STAT, v); chk("R2 status read-only", v, 0);

    // R4: unimplemented slots and high addresses
    wr(7'h20, 32'h55); wr(7'h34, 32'h77); wr(7'h48, 32'h1);
    rd(7'h20, v); chk("R4 slot2 reads zero", v, 0);
    rd(7'h34, v); chk("R4 slot3 reads zero", v, 0);
    rd(7'h48, v); chk("R4 high address reads zero", v, 0);
    rd(STAT, v);  chk("R4 status untouched", v, 0);
    rd(7'h00, v); chk("R4 ch0 control untouched", v, 0);
    rd(7'h04, v); chk("R4 ch0 prescaler untouched", v, 32'h123);

    // R5/R6/R7: random configurations
    for (int it = 0; it < 14; it++) begin
      int ch, p, q, d, P;
      bit inv;
      ch = int'($urandom_range(1, 0));
      p = int'($urandom_range(3, 0));
      q = int'($urandom_range(20, 1));
      d = int'($urandom_range(q + 2, 0));
      inv = bit'($urandom_range(1, 0));
      if (it == 0) d = 0;
      if (it == 1) d = q + 1;
      if (it == 2) inv = 1'b1;
      cfg(ch, p, q, d, inv ? INV : 32'h0);
      P = exp_period(p, q);
      if (d == 0) begin
        count_active(ch, inv, 2 * P, act);
        chk(inv ? "R6/R7 duty 0 inactive (inverted)" : "R6 duty 0 inactive", 32'(act), 0);
      end else if (d > q) begin
        count_active(ch, inv, 2 * P, act);
        chk(inv ? "R6/R7 duty>period active (inverted)" : "R6 duty>period active", 32'(act), 32'(2 * P));
      end else begin
        measure(ch, inv, per, hi);
        measure(ch, inv, per, hi);
        chk(inv ? "R5/R7 period (inverted)" : "R5 period", 32'(per), 32'(P));
        chk(inv ? "R5/R7 active time (inverted)" : "R5 active time", 32'(hi), 32'(exp_high(p, d)));
      end
    end

    // R8: autoload defers duty until wrap
    cfg(0, 0, 199, 50, AUTO);
    wait_rise(0, 1'b0);
    wr(7'h0C, 32'd150);
    repeat (5) @(negedge clk);
    rd(STAT, v); chk("R8 duty still pending before wrap", v & 32'hF, 32'h8);
    wait_idle(400, n);
    chk("R8 pending held well past sync delay", 32'(n > 100), 1);
    measure(0, 1'b0, per, hi);
    chk("R8 new duty after wrap", 32'(hi), 32'd150);
    chk("R8 period kept", 32'(per), 32'd200);

    // R10: force-load bits bypass autoload
    wr(7'h00, EN | AUTO | LDPER);
    wait_idle(50, n);
    wait_rise(0, 1'b0);
    wr(7'h0C, 32'd30);
    @(negedge clk); @(negedge clk);
    rd(STAT, v); chk("R10 duty forced on arrival", v, 0);
    measure(0, 1'b0, per, hi);
    chk("R10 forced duty in use", 32'(hi), 32'd30);
    wr(7'h00, EN | AUTO | LDPRE);
    wait_idle(50, n);
    wait_rise(0, 1'b0);
    wr(7'h04, 32'd0);
    @(negedge clk); @(negedge clk);
    rd(STAT, v); chk("R10 prescaler forced on arrival", v, 0);

    // R9: no autoload, transfer at next prescaler tick
    cfg(0, 7, 30, 5, 32'h0);
    repeat (13) @(negedge clk);
    wr(7'h0C, 32'd10);
    wait_idle(50, n);
    chk("R9 transfer within p+2 cycles", 32'(n <= 9), 1);
    measure(0, 1'b0, per, hi);
    measure(0, 1'b0, per, hi);
    chk("R9 new duty active time", 32'(hi), 32'(exp_high(7, 10)));

    // R12: stop at period end
    cfg(1, 0, 99, 99, 32'h0);
    wait_rise(1, 1'b0);
    repeat (10) @(negedge clk);
    wr(7'h10, 32'h0);
    repeat (20) @(negedge clk);
    chk("R12 output continues after disable", 32'(pwm_out[1]), 1);
    repeat (100) @(negedge clk);
    chk("R12 output stopped after wrap", 32'(pwm_out[1]), 0);
    count_active(1, 1'b0, 60, act);
    chk("R12 stays inactive", 32'(act), 0);

    // R11: stop immediately
    cfg(1, 0, 99, 99, 32'h0);
    wait_rise(1, 1'b0);
    repeat (10) @(negedge clk);
    wr(7'h10, STOP);
    @(negedge clk); @(negedge clk);
    chk("R11 active before stop lands", 32'(pwm_out[1]), 1);
    @(negedge clk);
    chk("R11 inactive on third edge", 32'(pwm_out[1]), 0);
    count_active(1, 1'b0, 150, act);
    chk("R11 stays inactive", 32'(act), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule